// File: doc/BRIEF.md
# Word-Serial Block Cipher Data-Phase Controller

This block sits between a 32-bit register bus and a 128-bit block cipher core. It collects a block as four 32-bit writes to an input data register, starts the core, and captures the 128-bit result when the core reports done. It then hands the result back as four 32-bit reads from an output data register. A three-state phase machine (input, compute, output) follows each block. After the last output word has been read, the machine goes straight back to the input phase, so blocks can stream one after another without software action.

Each word can be moved by software or by a DMA engine. The controller raises a single-request line for each word and holds it until the matching register access. DMA is allowed only in the encryption and decryption modes. A read of the output register in the wrong phase returns zero and sets a read-error flag. A write of the input register in the wrong phase is dropped and sets a write-error flag. In both cases processing carries on. An error interrupt is raised from the error flags. Clearing the enable bit aborts a block at any point.

Register map (word addresses on `bus_addr`): 0 control, 1 status, 2 input data, 3 output data.

Top module: `cipher_word_seq`

## Requirements
- R1: Four accepted writes to the input data register (address 2) fill the 128-bit block most significant word first: the first write lands in `core_din[127:96]` and the fourth in `core_din[31:0]`. `core_start` pulses for exactly one cycle, in the cycle after the edge that takes the fourth write.
- R2: After the core reports done, four reads of the output data register (address 3) return `core_dout[127:96]`, `[95:64]`, `[63:32]` and `[31:0]`, in that order, with no byte or bit reordering.
- R3: Status bits [4:3] give the phase: 0 input, 1 compute, 2 output. The fourth output read returns the machine to phase 0, and the next block is accepted with no further setup.
- R4: Status bit 0 (computation complete) is set when the core reports done. It stays set, in both software and DMA operation, until a control write with bit 8 set clears it.
- R5: A read of address 3 during the input or compute phase returns zero and sets status bit 1 (read error). The block still completes and returns a correct result.
- R6: A write of address 2 during the compute or output phase sets status bit 2 (write error) and leaves `core_din` and the pending result unchanged.
- R7: `irq` is high exactly when control bit 5 (error interrupt enable) is set and status bit 1 or bit 2 is set. Control writes with bit 9 or bit 10 set clear the read-error or write-error flag.
- R8: With control bit 0 (enable) set, mode 1 or 3 selected, and control bit 3 (DMA input enable) set, `dma_in_req` is high during the input phase. It drops in the same cycle as the input-register write and comes back for the next word.
- R9: With enable set, mode 1 or 3 selected, and control bit 4 (DMA output enable) set, `dma_out_req` is high during the output phase. It drops in the same cycle as each output-register read, which gives four requests per block.
- R10: In mode 2 neither DMA request is ever raised, whatever the DMA enable bits hold.
- R11: While enable is 0 the phase is held at input with the word count cleared. Clearing enable aborts a block at any point, and a core done that arrives after the abort is ignored. After reset the control and status registers read zero and all outputs are low.
- R12: The mode field (control bits [2:1]) takes a written value only when enable is 0 before the write. The enable, DMA enable and interrupt enable bits can be written at any time.
- R13: While enable is 0, input-register writes and output-register reads have no effect: reads return zero and no error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| dma_in_req | output | 1 | DMA single request for one input word |
| dma_out_req | output | 1 | DMA single request for one output word |
| irq | output | 1 | Error interrupt |
| core_start | output | 1 | One-cycle start pulse to the cipher core |
| core_mode | output | 2 | Operating mode passed to the core |
| core_din | output | 128 | Collected input block |
| core_done | input | 1 | Core result valid pulse |
| core_dout | input | 128 | Core result |

## Verification
A wrong word counter or phase shows up at the ports within one block. Words land in the wrong lane of `core_din`, `core_start` fires early or late, or an output read returns another lane or zero. Phase faults also show right away in status bits [4:3] and in the DMA request lines, which the bench samples in the cycle of each access. Corrupted flag state shows on the next status read and on `irq`. Abort and wrong-phase faults show on the next block, as a start from a partly filled buffer or a result that a late done has overwritten.

// File: rtl/cws_pkg.sv
package cws_pkg;

  typedef enum logic [1:0] {
    PH_IN   = 2'd0,
    PH_CALC = 2'd1,
    PH_OUT  = 2'd2
  } phase_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DIN  = 2'd2;
  localparam logic [1:0] A_DOUT = 2'd3;

  localparam int B_EN      = 0;
  localparam int B_MODE    = 1;
  localparam int B_DMAI    = 3;
  localparam int B_DMAO    = 4;
  localparam int B_EIE     = 5;
  localparam int B_CLR_CCF = 8;
  localparam int B_CLR_RD  = 9;
  localparam int B_CLR_WR  = 10;

  localparam int S_CCF = 0;
  localparam int S_RD  = 1;
  localparam int S_WR  = 2;
  localparam int S_PH  = 3;

  localparam logic [1:0] MODE_KEYDER = 2'd2;

  typedef struct packed {
    logic       en;
    logic [1:0] mode;
    logic       dma_i;
    logic       dma_o;
    logic       eie;
  } cfg_t;

endpackage

// File: rtl/cws_ctrl_regs.sv
module cws_ctrl_regs
  import cws_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  cfg_t cfg_wr,
  input  logic clr_ccf,
  input  logic clr_rd,
  input  logic clr_wr,
  input  logic set_ccf,
  input  logic set_rd,
  input  logic set_wr,
  output cfg_t cfg,
  output logic ccf,
  output logic rderr,
  output logic wrerr,
  output logic irq
);

  cfg_t cfg_d;
  logic ccf_d, rd_d, wr_d;

  always_comb begin
    cfg_d = cfg;
    if (ctrl_wr) begin
      cfg_d.en    = cfg_wr.en;
      cfg_d.dma_i = cfg_wr.dma_i;
      cfg_d.dma_o = cfg_wr.dma_o;
      cfg_d.eie   = cfg_wr.eie;
      if (!cfg.en) cfg_d.mode = cfg_wr.mode;
    end
    ccf_d = set_ccf | (ccf   & ~(ctrl_wr & clr_ccf));
    rd_d  = set_rd  | (rderr & ~(ctrl_wr & clr_rd));
    wr_d  = set_wr  | (wrerr & ~(ctrl_wr & clr_wr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      ccf   <= 1'b0;
      rderr <= 1'b0;
      wrerr <= 1'b0;
    end else begin
      if (ctrl_wr) cfg <= cfg_d;
      ccf   <= ccf_d;
      rderr <= rd_d;
      wrerr <= wr_d;
    end
  end

  assign irq = cfg.eie & (rderr | wrerr);

  // R12
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && cfg.en) |=> (cfg.mode == $past(cfg.mode)));

  // R4
  ccf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ccf && !(ctrl_wr && clr_ccf)) |=> ccf);

  // R7
  rderr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && clr_rd && !set_rd) |=> !rderr);

endmodule

// File: rtl/cws_phase_fsm.sv
module cws_phase_fsm
  import cws_pkg::*;
#(
  parameter int NW = 4,
  localparam int CW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          din_ok,
  input  logic          dout_ok,
  input  logic          core_done,
  output phase_e        phase,
  output logic [CW-1:0] cnt,
  output logic          start,
  output logic          capture
);

  localparam logic [CW-1:0] LAST = CW'(NW - 1);

  phase_e        ph_d;
  logic [CW-1:0] cnt_d;
  logic          start_d;

  always_comb begin
    ph_d    = phase;
    cnt_d   = cnt;
    start_d = 1'b0;
    capture = 1'b0;
    if (!en) begin
      ph_d  = PH_IN;
      cnt_d = '0;
    end else begin
      unique case (phase)
        PH_IN: if (din_ok) begin
          if (cnt == LAST) begin
            ph_d    = PH_CALC;
            cnt_d   = '0;
            start_d = 1'b1;
          end else begin
            cnt_d = cnt + 1'b1;
          end
        end
        PH_CALC: if (core_done) begin
          ph_d    = PH_OUT;
          cnt_d   = '0;
          capture = 1'b1;
        end
        PH_OUT: if (dout_ok) begin
          if (cnt == LAST) begin
            ph_d  = PH_IN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt + 1'b1;
          end
        end
        default: begin
          ph_d  = PH_IN;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IN;
      cnt   <= '0;
      start <= 1'b0;
    end else begin
      phase <= ph_d;
      cnt   <= cnt_d;
      start <= start_d;
    end
  end

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase == PH_IN && cnt == '0));

  // R1
  start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (phase == PH_CALC));

  // R3
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OUT && dout_ok && cnt == LAST) |=> (phase == PH_IN));

endmodule

// File: rtl/cws_word_buf.sv
module cws_word_buf #(
  parameter int DW = 32,
  parameter int NW = 4,
  localparam int CW = (NW > 1) ? $clog2(NW) : 1,
  localparam int BW = DW * NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din_ok,
  input  logic [CW-1:0] cnt,
  input  logic [DW-1:0] wdata,
  input  logic          capture,
  input  logic [BW-1:0] core_dout,
  output logic [BW-1:0] in_blk,
  output logic [DW-1:0] out_word
);

  logic [DW-1:0] out_q [NW];

  for (genvar gi = 0; gi < NW; gi++) begin : g_lane
    localparam int HI = BW - 1 - gi * DW;
    logic ld_in;
    assign ld_in = din_ok && (cnt == CW'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     in_blk[HI -: DW] <= '0;
      else if (ld_in) in_blk[HI -: DW] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       out_q[gi] <= '0;
      else if (capture) out_q[gi] <= core_dout[HI -: DW];
    end
  end

  assign out_word = out_q[cnt];

endmodule

// File: rtl/cipher_word_seq.sv
module cipher_word_seq
  import cws_pkg::*;
#(
  parameter int DW = 32,
  parameter int NW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             dma_in_req,
  output logic             dma_out_req,
  output logic             irq,
  output logic             core_start,
  output logic [1:0]       core_mode,
  output logic [DW*NW-1:0] core_din,
  input  logic             core_done,
  input  logic [DW*NW-1:0] core_dout
);

  localparam int CW = (NW > 1) ? $clog2(NW) : 1;

  cfg_t          cfg, cfg_wr;
  logic          ccf, rderr, wrerr;
  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          capture;
  logic [DW-1:0] out_word;
  logic          ctrl_wr, wr_din, rd_dout;
  logic          din_ok, dout_ok, set_rd, set_wr, dma_ok;

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign wr_din  = bus_wr && (bus_addr == A_DIN);
  assign rd_dout = bus_rd && (bus_addr == A_DOUT);

  assign din_ok  = cfg.en && wr_din  && (phase == PH_IN);
  assign dout_ok = cfg.en && rd_dout && (phase == PH_OUT);
  assign set_wr  = cfg.en && wr_din  && (phase != PH_IN);
  assign set_rd  = cfg.en && rd_dout && (phase != PH_OUT);

  always_comb begin
    cfg_wr       = '0;
    cfg_wr.en    = bus_wdata[B_EN];
    cfg_wr.mode  = bus_wdata[B_MODE +: 2];
    cfg_wr.dma_i = bus_wdata[B_DMAI];
    cfg_wr.dma_o = bus_wdata[B_DMAO];
    cfg_wr.eie   = bus_wdata[B_EIE];
  end

  cws_ctrl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .cfg_wr  (cfg_wr),
    .clr_ccf (bus_wdata[B_CLR_CCF]),
    .clr_rd  (bus_wdata[B_CLR_RD]),
    .clr_wr  (bus_wdata[B_CLR_WR]),
    .set_ccf (capture),
    .set_rd  (set_rd),
    .set_wr  (set_wr),
    .cfg     (cfg),
    .ccf     (ccf),
    .rderr   (rderr),
    .wrerr   (wrerr),
    .irq     (irq)
  );

  cws_phase_fsm #(.NW(NW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg.en),
    .din_ok    (din_ok),
    .dout_ok   (dout_ok),
    .core_done (core_done),
    .phase     (phase),
    .cnt       (cnt),
    .start     (core_start),
    .capture   (capture)
  );

  cws_word_buf #(.DW(DW), .NW(NW)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .din_ok    (din_ok),
    .cnt       (cnt),
    .wdata     (bus_wdata),
    .capture   (capture),
    .core_dout (core_dout),
    .in_blk    (core_din),
    .out_word  (out_word)
  );

  assign core_mode = cfg.mode;

  // DMA only in the cipher modes; each request drops in its access cycle
  assign dma_ok      = cfg.en && (cfg.mode == 2'd1 || cfg.mode == 2'd3);
  assign dma_in_req  = dma_ok && cfg.dma_i && (phase == PH_IN)  && !wr_din;
  assign dma_out_req = dma_ok && cfg.dma_o && (phase == PH_OUT) && !rd_dout;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        A_CTRL: begin
          bus_rdata[B_EN]       = cfg.en;
          bus_rdata[B_MODE +: 2] = cfg.mode;
          bus_rdata[B_DMAI]     = cfg.dma_i;
          bus_rdata[B_DMAO]     = cfg.dma_o;
          bus_rdata[B_EIE]      = cfg.eie;
        end
        A_STAT: begin
          bus_rdata[S_CCF]      = ccf;
          bus_rdata[S_RD]       = rderr;
          bus_rdata[S_WR]       = wrerr;
          bus_rdata[S_PH +: 2]  = phase;
        end
        A_DOUT:  bus_rdata = dout_ok ? out_word : '0;
        default: bus_rdata = '0;
      endcase
    end
  end

  // R8
  dma_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_in_req && dma_out_req));

  // R10
  keyder_no_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MODE_KEYDER) |-> (!dma_in_req && !dma_out_req));

  // R5
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dout && phase != PH_OUT) |-> (bus_rdata == '0));

  // R6
  din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_din && phase != PH_IN) |=> $stable(core_din));

endmodule

// File: tb/cipher_word_seq_tb.sv
module cipher_word_seq_tb;

  localparam int LAT = 5;
  localparam logic [127:0] MASK = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
  localparam logic [127:0] VEC [4] = '{
    128'h00112233_44556677_8899AABB_CCDDEEFF,
    128'hFFFFFFFF_00000000_FFFFFFFF_00000000,
    128'h80000000_00000000_00000000_00000001,
    128'hDEADBEEF_CAFEF00D_12345678_9ABCDEF0
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_wr, bus_rd;
  logic [1:0]   bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic         dma_in_req, dma_out_req, irq, core_start, core_done;
  logic [1:0]   core_mode;
  logic [127:0] core_din, core_dout;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cipher_word_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_in_req(dma_in_req), .dma_out_req(dma_out_req), .irq(irq),
    .core_start(core_start), .core_mode(core_mode), .core_din(core_din),
    .core_done(core_done), .core_dout(core_dout)
  );

  function automatic logic [127:0] cipher_f(input logic [127:0] d);
    return {d[95:0], d[127:96]} ^ MASK;
  endfunction

  // fixed-latency core stub
  int           stub_cnt;
  logic [127:0] stub_d;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stub_cnt  <= 0;
      core_done <= 1'b0;
      core_dout <= '0;
      stub_d    <= '0;
    end else begin
      core_done <= 1'b0;
      if (core_start) begin
        stub_cnt <= LAT;
        stub_d   <= core_din;
      end else if (stub_cnt > 0) begin
        stub_cnt <= stub_cnt - 1;
        if (stub_cnt == 1) begin
          core_done <= 1'b1;
          core_dout <= cipher_f(stub_d);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic put_block(input logic [127:0] b);
    for (int i = 0; i < 4; i++) wr(2'd2, b[127-32*i -: 32]);
  endtask

  task automatic wait_out();
    logic [31:0] s;
    for (int i = 0; i < 40; i++) begin
      rd(2'd1, s);
      if (s[4:3] == 2'd2) break;
    end
  endtask

  task automatic get_block(input string req, input logic [127:0] exp);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin
      rd(2'd3, w);
      chk(req, w, exp[127-32*i -: 32]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s;
    logic [127:0] nb;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(2'd0, s); chk("R11 ctrl reset", s, 0);
    rd(2'd1, s); chk("R11 status reset", s, 0);
    chk("R11 outputs reset", {dma_in_req, dma_out_req, irq, core_start}, 0);

    // software blocks, mode 1
    wr(2'd0, 32'h3);
    for (int v = 0; v < 4; v++) begin
      put_block(VEC[v]);
      if (v == 0) chk("R1 start pulse", core_start, 1);
      chk("R1 block assembly", core_din, VEC[v]);
      @(negedge clk);
      chk("R1 start single cycle", core_start, 0);
      wait_out();
      rd(2'd1, s); chk("R4 ccf set", s[0], 1);
      get_block("R2 output order", cipher_f(VEC[v]));
      rd(2'd1, s); chk("R3 back to input phase", s[4:3], 0);
      wr(2'd0, 32'h3 | 32'h100);
      rd(2'd1, s); chk("R4 ccf cleared", s[0], 0);
    end

    // R5 read errors, processing continues
    rd(2'd3, s); chk("R5 read in input returns zero", s, 0);
    rd(2'd1, s); chk("R5 rderr set", s[1], 1);
    chk("R7 irq off without enable", irq, 0);
    put_block(VEC[1]);
    rd(2'd3, s); chk("R5 read in compute returns zero", s, 0);
    wait_out();
    get_block("R5 block still completes", cipher_f(VEC[1]));
    wr(2'd0, 32'h3 | 32'h20);
    @(negedge clk); chk("R7 irq on rderr", irq, 1);
    wr(2'd0, 32'h3 | 32'h20 | 32'h200);
    @(negedge clk); chk("R7 irq cleared", irq, 0);
    rd(2'd1, s); chk("R7 rderr cleared", s[1], 0);

    // R6 write errors
    put_block(VEC[2]);
    wr(2'd2, 32'h5555AAAA);
    rd(2'd1, s); chk("R6 wrerr set in compute", s[2], 1);
    chk("R6 input kept", core_din, VEC[2]);
    chk("R7 irq on wrerr", irq, 1);
    wait_out();
    wr(2'd2, 32'h12121212);
    chk("R6 input kept in output phase", core_din, VEC[2]);
    get_block("R6 result unaffected", cipher_f(VEC[2]));
    wr(2'd0, 32'h3 | 32'h20 | 32'h400 | 32'h100);
    @(negedge clk); chk("R7 wrerr clear drops irq", irq, 0);

    // R8 R9 DMA, mode 1
    wr(2'd0, 32'h3 | 32'h8 | 32'h10);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk("R8 in req before access", dma_in_req, 1);
      bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = VEC[3][127-32*i -: 32];
      #1 chk("R8 in req drops at access", dma_in_req, 0);
      @(negedge clk); bus_wr = 1'b0;
    end
    #1 chk("R8 no in req in compute", dma_in_req, 0);
    for (int i = 0; i < 40 && !dma_out_req; i++) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk("R9 out req before access", dma_out_req, 1);
      bus_rd = 1'b1; bus_addr = 2'd3;
      #1 chk("R9 out req drops at access", dma_out_req, 0);
      chk("R2 dma word order", bus_rdata, cipher_f(VEC[3])[127-32*i -: 32]);
      @(negedge clk); bus_rd = 1'b0;
    end
    #1 chk("R9 out req ends after four", dma_out_req, 0);
    chk("R3 dma rearms input", dma_in_req, 1);
    rd(2'd1, s); chk("R4 ccf kept in dma mode", s[0], 1);

    // R10 key derivation mode: no DMA
    wr(2'd0, 32'h18 | 32'h100);
    wr(2'd0, 32'h5 | 32'h18);
    @(negedge clk); chk("R10 no in req in mode 2", dma_in_req, 0);
    put_block(VEC[0]);
    wait_out();
    chk("R10 no out req in mode 2", dma_out_req, 0);
    get_block("R10 software path in mode 2", cipher_f(VEC[0]));

    // R12 mode lock
    wr(2'd0, 32'h7);
    rd(2'd0, s); chk("R12 mode locked while enabled", s[2:1], 2);
    chk("R12 core mode", core_mode, 2);
    wr(2'd0, 32'h0);
    wr(2'd0, 32'h3);
    rd(2'd0, s); chk("R12 mode written while disabled", s[2:1], 1);

    // R11 abort during compute, late done ignored
    wr(2'd0, 32'h3 | 32'h100);
    put_block(VEC[1]);
    wr(2'd0, 32'h2);
    repeat (10) @(negedge clk);
    rd(2'd1, s); chk("R11 abort leaves idle input", s, 0);
    // R11 abort mid input clears word count
    wr(2'd0, 32'h3);
    wr(2'd2, 32'hAAAAAAAA);
    wr(2'd2, 32'hBBBBBBBB);
    wr(2'd0, 32'h2);
    // R13 disabled accesses have no effect
    wr(2'd2, 32'h77777777);
    rd(2'd3, s); chk("R13 disabled read zero", s, 0);
    rd(2'd1, s); chk("R13 no error while disabled", s, 0);
    wr(2'd0, 32'h3);
    nb = 128'h01020304_05060708_090A0B0C_0D0E0F10;
    put_block(nb);
    chk("R11 fresh block after abort", core_din, nb);
    chk("R11 start after four fresh words", core_start, 1);
    wait_out();
    get_block("R11 result after abort", cipher_f(nb));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule